// File: doc/BRIEF.md
# Sample-Rate Paced Transmit Slot Feeder

This block sits on the host side of a serial codec link and feeds conversion samples into two fixed 16-bit fields, audio and telecom, of every outgoing frame. Each channel has three parts. A small transmit queue accepts samples from a write port. A holding register supplies the channel's field value. A programmable down-counter paces how often the holding register takes a new sample.

The queue is not drained once per frame. A value in the holding register is repeated in every frame until the local counter reloads. The far-end converter keeps its own copy of this counter, so the reload marks the moment that end has used the sample. Software starts both counters together by raising the channel's enable, and the two counters stay in step from then on. If the queue is empty when a new sample is needed, the field keeps its old value and a sticky underrun flag is raised.

Top module: `tx_slot_feeder`

## Requirements
- R1: After synchronous reset, both field outputs are 0, both queues report empty=1, full=0 and level 0, and both underrun flags are 0.
- R2: Each queue holds up to 8 sixteen-bit entries in arrival order. The level output gives the entry count, full is 1 at 8 entries and empty is 1 at 0. A write while full is dropped, so that value is never delivered.
- R3: On the first clock edge at which a channel's enable is sampled 1 after being 0, the oldest queued entry moves into that channel's field, and the channel's counter is loaded with its modulus input.
- R4: While a channel is enabled and no frame-start strobe arrives, its field does not change.
- R5: At each frame-start strobe while enabled (and not on the enable's first edge), the counter decrements if it is nonzero. If it is zero, it reloads with the modulus and the next entry moves into the field. A new entry therefore appears every modulus+1 strobes.
- R6: While a channel's enable is 0, its counter and field hold their values, and strobes have no effect on either.
- R7: A take from an empty queue leaves the field unchanged and sets that channel's underrun flag. The flag stays 1 until reset.
- R8: The audio and telecom channels are independent. Writes, enables and moduli of one never affect the field, queue or flag of the other.
- R9: When the strobe coincides with the enable's first edge, the enable takes precedence. The counter loads the modulus and that strobe is not counted as a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | One-cycle pulse per outgoing frame |
| aud_en | input | 1 | Audio channel enable |
| aud_modulus | input | CNT_W | Audio counter reload value |
| aud_wr | input | 1 | Audio queue write strobe |
| aud_wdata | input | DATA_W | Audio queue write data |
| tel_en | input | 1 | Telecom channel enable |
| tel_modulus | input | CNT_W | Telecom counter reload value |
| tel_wr | input | 1 | Telecom queue write strobe |
| tel_wdata | input | DATA_W | Telecom queue write data |
| aud_field | output | DATA_W | Audio field value for the current frame |
| tel_field | output | DATA_W | Telecom field value for the current frame |
| aud_full | output | 1 | Audio queue full |
| aud_empty | output | 1 | Audio queue empty |
| aud_level | output | LVL_W | Audio queue entry count |
| tel_full | output | 1 | Telecom queue full |
| tel_empty | output | 1 | Telecom queue empty |
| tel_level | output | LVL_W | Telecom queue entry count |
| aud_underrun | output | 1 | Sticky audio underrun flag |
| tel_underrun | output | 1 | Sticky telecom underrun flag |

## Verification
The bench keeps the default depth of 8 and the 16-bit data width, but narrows the counter width to 4 bits. It drives moduli of 0 to 3, so reloads happen every one to four strobes. With this fast pacing, a queue runs from full to empty and into underrun within a few dozen cycles. Both the dropped-write path and the empty-take path are therefore exercised many times in the random phase, alongside the directed enable-edge and strobe-collision cases.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int NUM_CH = 2;
  typedef enum int {
    CH_AUD = 0,
    CH_TEL = 1
  } ch_e;
endpackage

// File: rtl/tsf_fifo.sv
module tsf_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [LVL_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [LVL_W-1:0]  cnt;
  logic              do_wr, do_rd;

  assign full  = (cnt == LVL_W'(DEPTH));
  assign empty = (cnt == '0);
  assign level = cnt;
  assign do_wr = wr_en && !full;   // R2: writes when full are dropped
  assign do_rd = rd_en && !empty;
  assign rd_data = mem[rp];

  // storage without reset so it maps onto RAM resources
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + LVL_W'(1);
        2'b01:   cnt <= cnt - LVL_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tsf_rate_counter.sv
module tsf_rate_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             strobe,
  input  logic [CNT_W-1:0] modulus,
  output logic             take
);
  logic [CNT_W-1:0] cnt;
  logic             en_q;
  logic             rise;
  logic             wrap;

  assign rise = en && !en_q;                           // R3
  assign wrap = en && strobe && !rise && (cnt == '0);  // R5, R9
  assign take = rise || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else begin
      en_q <= en;
      if (rise || wrap)
        cnt <= modulus;
      else if (en && strobe)
        cnt <= cnt - CNT_W'(1);
      // R6: disabled -> hold
    end
  end
endmodule

// File: rtl/tsf_channel.sv
module tsf_channel #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              en,
  input  logic [CNT_W-1:0]  modulus,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] field,
  output logic              full,
  output logic              empty,
  output logic [LVL_W-1:0]  level,
  output logic              underrun
);
  logic              take;
  logic [DATA_W-1:0] head;

  tsf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(take), .rd_data(head), .full(full), .empty(empty), .level(level)
  );

  tsf_rate_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .strobe(strobe),
    .modulus(modulus), .take(take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      field    <= '0;
      underrun <= 1'b0;
    end else if (take) begin
      if (empty) underrun <= 1'b1;   // R7: keep old field
      else       field    <= head;   // R3, R5
    end
  end
endmodule

// File: rtl/tx_slot_feeder.sv
module tx_slot_feeder
  import tsf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_strobe,
  input  logic              aud_en,
  input  logic [CNT_W-1:0]  aud_modulus,
  input  logic              aud_wr,
  input  logic [DATA_W-1:0] aud_wdata,
  input  logic              tel_en,
  input  logic [CNT_W-1:0]  tel_modulus,
  input  logic              tel_wr,
  input  logic [DATA_W-1:0] tel_wdata,
  output logic [DATA_W-1:0] aud_field,
  output logic [DATA_W-1:0] tel_field,
  output logic              aud_full,
  output logic              aud_empty,
  output logic [LVL_W-1:0]  aud_level,
  output logic              tel_full,
  output logic              tel_empty,
  output logic [LVL_W-1:0]  tel_level,
  output logic              aud_underrun,
  output logic              tel_underrun
);
  logic              en_a   [NUM_CH];
  logic [CNT_W-1:0]  mod_a  [NUM_CH];
  logic              wr_a   [NUM_CH];
  logic [DATA_W-1:0] wd_a   [NUM_CH];
  logic [DATA_W-1:0] fld_a  [NUM_CH];
  logic              full_a [NUM_CH];
  logic              emp_a  [NUM_CH];
  logic [LVL_W-1:0]  lvl_a  [NUM_CH];
  logic              und_a  [NUM_CH];

  assign en_a[CH_AUD]  = aud_en;       assign en_a[CH_TEL]  = tel_en;
  assign mod_a[CH_AUD] = aud_modulus;  assign mod_a[CH_TEL] = tel_modulus;
  assign wr_a[CH_AUD]  = aud_wr;       assign wr_a[CH_TEL]  = tel_wr;
  assign wd_a[CH_AUD]  = aud_wdata;    assign wd_a[CH_TEL]  = tel_wdata;

  // R8: one independent channel per field
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tsf_channel #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .strobe(frame_strobe), .en(en_a[c]),
      .modulus(mod_a[c]), .wr_en(wr_a[c]), .wr_data(wd_a[c]),
      .field(fld_a[c]), .full(full_a[c]), .empty(emp_a[c]),
      .level(lvl_a[c]), .underrun(und_a[c])
    );
  end

  assign aud_field    = fld_a[CH_AUD];  assign tel_field    = fld_a[CH_TEL];
  assign aud_full     = full_a[CH_AUD]; assign tel_full     = full_a[CH_TEL];
  assign aud_empty    = emp_a[CH_AUD];  assign tel_empty    = emp_a[CH_TEL];
  assign aud_level    = lvl_a[CH_AUD];  assign tel_level    = lvl_a[CH_TEL];
  assign aud_underrun = und_a[CH_AUD];  assign tel_underrun = und_a[CH_TEL];
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_strobe,
  input logic              aud_en,
  input logic              tel_en,
  input logic              aud_wr,
  input logic [DATA_W-1:0] aud_field,
  input logic [DATA_W-1:0] tel_field,
  input logic              aud_full,
  input logic              aud_empty,
  input logic [LVL_W-1:0]  aud_level,
  input logic              tel_full,
  input logic              tel_empty,
  input logic              aud_underrun,
  input logic              tel_underrun
);
  AST_AUD_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(aud_full && aud_empty)); // R2
  AST_TEL_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(tel_full && tel_empty)); // R2
  AST_AUD_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst) aud_level <= LVL_W'(DEPTH)); // R2
  AST_AUD_FULL_DROP: assert property (@(posedge clk) disable iff (rst) (aud_full && aud_wr && !aud_en) |=> aud_level == $past(aud_level)); // R2
  AST_AUD_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst) (aud_en && $past(aud_en) && !$past(rst) && !frame_strobe) |=> $stable(aud_field)); // R4
  AST_AUD_OFF_HOLD: assert property (@(posedge clk) disable iff (rst) !aud_en |=> $stable(aud_field)); // R6
  AST_TEL_OFF_HOLD: assert property (@(posedge clk) disable iff (rst) !tel_en |=> $stable(tel_field)); // R6
  AST_AUD_UNDER_STICKY: assert property (@(posedge clk) disable iff (rst) aud_underrun |=> aud_underrun); // R7
  AST_TEL_UNDER_STICKY: assert property (@(posedge clk) disable iff (rst) tel_underrun |=> tel_underrun); // R7
  AST_AUD_UNDER_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(aud_underrun) |-> $past(aud_empty)); // R7
endmodule

bind tx_slot_feeder tsf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/tx_slot_feeder_test.sv
`timescale 1ns/1ps
module tx_slot_feeder_test;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int CW = 4;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic          b_en  [2];
  logic [CW-1:0] b_mod [2];
  logic          b_wr  [2];
  logic [DW-1:0] b_wd  [2];
  logic [DW-1:0] aud_field, tel_field;
  logic aud_full, aud_empty, tel_full, tel_empty, aud_underrun, tel_underrun;
  logic [LW-1:0] aud_level, tel_level;

  int nchk = 0;
  int nfail = 0;

  // model state
  int            m_cnt  [2];
  int            m_size [2];
  int            m_head [2];
  logic [DW-1:0] m_buf  [2][DEPTH];
  logic [DW-1:0] m_hold [2];
  bit            m_enq  [2];
  bit            m_under[2];

  always #2.5 clk = ~clk;

  tx_slot_feeder #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .frame_strobe(strobe),
    .aud_en(b_en[0]), .aud_modulus(b_mod[0]), .aud_wr(b_wr[0]), .aud_wdata(b_wd[0]),
    .tel_en(b_en[1]), .tel_modulus(b_mod[1]), .tel_wr(b_wr[1]), .tel_wdata(b_wd[1]),
    .aud_field(aud_field), .tel_field(tel_field),
    .aud_full(aud_full), .aud_empty(aud_empty), .aud_level(aud_level),
    .tel_full(tel_full), .tel_empty(tel_empty), .tel_level(tel_level),
    .aud_underrun(aud_underrun), .tel_underrun(tel_underrun)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic check(string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_size[c] = 0; m_head[c] = 0;
      m_hold[c] = '0; m_enq[c] = 0; m_under[c] = 0;
    end
  endfunction

  function automatic void model_ch(int c);
    bit rise, take, was_full, was_empty;
    rise = b_en[c] && !m_enq[c];
    take = 0;
    if (rise) begin
      m_cnt[c] = b_mod[c]; take = 1;
    end else if (b_en[c] && strobe) begin
      if (m_cnt[c] == 0) begin m_cnt[c] = b_mod[c]; take = 1; end
      else m_cnt[c]--;
    end
    was_full  = (m_size[c] == DEPTH);
    was_empty = (m_size[c] == 0);
    if (take) begin
      if (was_empty) m_under[c] = 1;
      else begin
        m_hold[c] = m_buf[c][m_head[c]];
        m_head[c] = (m_head[c] + 1) % DEPTH;
        m_size[c]--;
      end
    end
    if (b_wr[c] && !was_full) begin
      m_buf[c][(m_head[c] + m_size[c]) % DEPTH] = b_wd[c];
      m_size[c]++;
    end
    m_enq[c] = b_en[c];
  endfunction

  task automatic compare(string ta, string tt);
    check({ta, " aud_field"}, int'(aud_field), int'(m_hold[0]));
    check({ta, " aud_level"}, int'(aud_level), m_size[0]);
    check({ta, " aud_full"},  int'(aud_full),  int'(m_size[0] == DEPTH));
    check({ta, " aud_empty"}, int'(aud_empty), int'(m_size[0] == 0));
    check({ta, " aud_underrun"}, int'(aud_underrun), int'(m_under[0]));
    check({tt, " tel_field"}, int'(tel_field), int'(m_hold[1]));
    check({tt, " tel_level"}, int'(tel_level), m_size[1]);
    check({tt, " tel_full"},  int'(tel_full),  int'(m_size[1] == DEPTH));
    check({tt, " tel_empty"}, int'(tel_empty), int'(m_size[1] == 0));
    check({tt, " tel_underrun"}, int'(tel_underrun), int'(m_under[1]));
  endtask

  task automatic cycle(string ta, string tt);
    @(posedge clk);
    model_ch(0);
    model_ch(1);
    @(negedge clk);
    compare(ta, tt);
    b_wr[0] = 0; b_wr[1] = 0; strobe = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    for (int c = 0; c < 2; c++) begin
      b_en[c] = 0; b_wr[c] = 0; b_wd[c] = '0; b_mod[c] = '0;
    end
    strobe = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    compare("R1", "R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R2: nine writes into audio, last one dropped; three into telecom
    for (int i = 0; i < 9; i++) begin
      b_wr[0] = 1; b_wd[0] = DW'(16'h1100 + i);
      if (i < 3) begin b_wr[1] = 1; b_wd[1] = DW'(16'h2200 + i); end
      cycle("R2", "R2");
    end

    // R3: enable audio without strobe, modulus 2; telecom stays off (R8)
    b_mod[0] = 2; b_en[0] = 1;
    cycle("R3", "R8");
    // R4: enabled, no strobe
    repeat (3) cycle("R4", "R8");
    // R5: strobes pace the takes (every 3rd strobe)
    for (int i = 0; i < 7; i++) begin strobe = 1; cycle("R5", "R8"); end
    // R6: disabled, strobes ignored
    b_en[0] = 0;
    for (int i = 0; i < 5; i++) begin strobe = 1; cycle("R6", "R6"); end
    // R9: re-enable together with a strobe
    b_en[0] = 1; strobe = 1;
    cycle("R9", "R8");
    for (int i = 0; i < 3; i++) begin strobe = 1; cycle("R9", "R8"); end

    // R7: telecom modulus 0 drains one entry per strobe into underrun
    b_mod[1] = 0; b_en[1] = 1;
    cycle("R8", "R3");
    for (int i = 0; i < 6; i++) begin strobe = 1; cycle("R8", "R7"); end
    // R7: a later write does not clear the flag, and fills the field
    b_wr[1] = 1; b_wd[1] = 16'hBEEF;
    cycle("R8", "R7");
    strobe = 1;
    cycle("R8", "R7");
    repeat (2) cycle("R8", "R7");

    // random phase
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < 2; c++) begin
        if ($urandom % 20 == 0) b_en[c] = !b_en[c];
        if ($urandom % 8 == 0) b_mod[c] = CW'($urandom % 4);
        b_wr[c] = ($urandom % 3 == 0);
        b_wd[c] = DW'($urandom);
      end
      strobe = ($urandom % 2 == 0);
      cycle("R5", "R5");
      if (n == 2000) do_reset();
    end

    summary();
    $finish;
  end
endmodule